// File: doc/BRIEF.md
# Tagged Word Load/Store Guard

This block sits between a register file and a memory port whose words each hold 64 data bits and an 8-bit tag. The tag lives in the side bits that would otherwise carry ECC. For every request from the core the block reads the addressed word together with its tag. It then applies the access rules for that kind of request. When a rule is broken it raises a trap and blocks the memory write in the same cycle. When no rule is broken it builds the tag that goes back to the register or out to memory. Place attributes describe where a word is stored, not its value. They are removed when a word moves into a register. When a register value is written back, the place attributes already held by the destination word are kept.

Tag layout, most significant bit first:
- bit 7: initialized.
- bit 6: executable.
- bit 5: pointer.
- bits 4:2: attribute field.
  - For a numeric word, bit 4 means the value is zero, bit 3 means it is negative, and bit 2 is the carry.
  - For a pointer, bit 4 means read-only through this pointer and bit 2 is the carry.
- bit 1: constant location.
- bit 0: global (coherent) location.

Operation codes:

| Code | Operation |
|------|-----------|
| 0 | load |
| 1 | instruction fetch |
| 2 | store |
| 3 | tag-modify |

Trap cause codes:

| Code | Cause |
|------|-------|
| 0 | none |
| 1 | uninitialized read |
| 2 | fetch of a word that is not executable |
| 3 | store to a constant location |
| 4 | store through a read-only pointer |
| 5 | store that would change the pointer/data type of an initialized word |

The control is a three-state machine:
- `ST_IDLE`: waits for a request. When `req_valid` is high it moves to `ST_READ`.
- `ST_READ`: issues the memory read and always moves to `ST_CHECK`.
- `ST_CHECK`: evaluates the rules, gives the response and any trap, and performs the write if one is allowed. It always returns to `ST_IDLE`.

Top module: `tagged_word_guard`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `trap_valid`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: A request accepted in `ST_IDLE` drives `mem_rd_en` with `mem_addr` equal to the request address during the next cycle, with `req_ready` low. The response (`rsp_valid`=1) and any trap follow in the cycle after that.
- R3: A load of a word whose initialized bit (bit 7) is 0 traps with cause 1. Otherwise the load returns the stored data.
- R4: A fetch traps with cause 1 if bit 7 is 0, else with cause 2 if the executable bit (bit 6) is 0.
- R5: The tag returned for a load or fetch that does not trap equals the stored tag with bits 1:0 cleared.
- R6: A store that does not trap writes `req_data` with tag bits 7:2 taken from `req_tag` and bits 1:0 taken from the destination's stored tag.
- R7: A store to a word with bit 1 set traps with cause 3, and `mem_wr_en` stays 0.
- R8: A store whose address-register tag `req_ptag` has bit 5 and bit 4 set traps with cause 4, ahead of cause 3. A `req_ptag` without bit 5 imposes no restriction.
- R9: A store to an initialized word whose bit 5 differs from bit 5 of `req_tag` traps with cause 5 and does not write. A destination with bit 7 clear takes any type.
- R10: Tag-modify writes `req_tag` as the whole new tag, including bits 1:0. It keeps the stored data and never traps, even on constant words.
- R11: For a load or fetch that does not trap and returns a non-pointer word, `cmp_zero` equals tag bit 4 and `cmp_neg` equals tag bit 3. Both are 0 for pointers, traps and other operations.
- R12: When a trap fires, `trap_addr` equals the request address and `trap_cause` is nonzero. Without a trap, `trap_cause` is 0 and no response data or tag is returned for stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_op | input | 2 | Operation code |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Register data for a store |
| req_tag | input | 8 | Register tag for a store, or the new tag for tag-modify |
| req_ptag | input | 8 | Tag of the address register used for a store |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Data to write |
| mem_wtag | output | 8 | Tag to write |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd_en` |
| mem_rtag | input | 8 | Read tag, valid the cycle after `mem_rd_en` |
| rsp_valid | output | 1 | Response cycle |
| rsp_data | output | DATA_W | Loaded or fetched data |
| rsp_tag | output | 8 | Register-side tag of the loaded word |
| cmp_zero | output | 1 | Zero taken from the stored attribute bits |
| cmp_neg | output | 1 | Negative taken from the stored attribute bits |
| trap_valid | output | 1 | Rule violation |
| trap_cause | output | 3 | Cause code |
| trap_addr | output | ADDR_W | Address of the faulting access |

## Verification
Suppose a request is sampled at clock edge k. The memory read is visible between edges k and k+1. The response, trap, compare bits and write strobe are visible between edges k+1 and k+2. A permitted write lands at edge k+2. Each scenario task drives inputs on the falling edge and samples the read phase after edge k. It samples all results after edge k+1 and confirms stored state by issuing a later load. It never samples on a rising edge.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
    localparam int TAG_W    = 8;
    localparam int B_INIT   = 7;
    localparam int B_EXEC   = 6;
    localparam int B_PTR    = 5;
    localparam int B_ATTR   = 4;  // zero (numeric) or read-only (pointer)
    localparam int B_SIGN   = 3;
    localparam int B_CONST  = 1;
    localparam int PLACE_W  = 2;  // bits [1:0]: constant, global

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_FETCH  = 2'd1,
        OP_STORE  = 2'd2,
        OP_TAGMOD = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        CS_NONE   = 3'd0,
        CS_UNINIT = 3'd1,
        CS_NOEXEC = 3'd2,
        CS_CONST  = 3'd3,
        CS_RDONLY = 3'd4,
        CS_TYPE   = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_CHECK = 2'd2
    } state_e;
endpackage

// File: rtl/tag_rule_eval.sv
module tag_rule_eval
    import tagchk_pkg::*;
(
    input  op_e              op,
    input  logic [TAG_W-1:0] mem_tag,
    input  logic [TAG_W-1:0] reg_tag,
    input  logic [TAG_W-1:0] ptr_tag,
    output cause_e           cause
);
    logic ro_ptr;
    logic type_clash;

    assign ro_ptr     = ptr_tag[B_PTR] & ptr_tag[B_ATTR];
    assign type_clash = mem_tag[B_INIT] & (mem_tag[B_PTR] != reg_tag[B_PTR]);

    always_comb begin
        cause = CS_NONE;
        unique case (op)
            OP_LOAD: begin
                if (!mem_tag[B_INIT]) cause = CS_UNINIT;
            end
            OP_FETCH: begin
                if (!mem_tag[B_INIT])      cause = CS_UNINIT;
                else if (!mem_tag[B_EXEC]) cause = CS_NOEXEC;
            end
            OP_STORE: begin
                if (ro_ptr)                 cause = CS_RDONLY;
                else if (mem_tag[B_CONST])  cause = CS_CONST;
                else if (type_clash)        cause = CS_TYPE;
            end
            OP_TAGMOD: cause = CS_NONE;
        endcase
    end
endmodule

// File: rtl/tag_merge.sv
module tag_merge
    import tagchk_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  op_e               op,
    input  logic [TAG_W-1:0]  mem_tag,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [TAG_W-1:0]  reg_tag,
    input  logic [DATA_W-1:0] reg_data,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic [TAG_W-1:0]  ld_tag,
    output logic              flag_zero,
    output logic              flag_neg
);
    localparam int VAL_W = TAG_W - PLACE_W;

    // register-side view: place bits dropped
    assign ld_tag    = {mem_tag[TAG_W-1:PLACE_W], {PLACE_W{1'b0}}};
    assign flag_zero = ~mem_tag[B_PTR] & mem_tag[B_ATTR];
    assign flag_neg  = ~mem_tag[B_PTR] & mem_tag[B_SIGN];

    always_comb begin
        if (op == OP_TAGMOD) begin
            wr_tag  = reg_tag;
            wr_data = mem_data;
        end else begin
            wr_tag  = {reg_tag[TAG_W-1 -: VAL_W], mem_tag[PLACE_W-1:0]};
            wr_data = reg_data;
        end
    end
endmodule

// File: rtl/tagged_word_guard.sv
module tagged_word_guard
    import tagchk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [7:0]        req_tag,
    input  logic [7:0]        req_ptag,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [7:0]        mem_wtag,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [7:0]        mem_rtag,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [7:0]        rsp_tag,
    output logic              cmp_zero,
    output logic              cmp_neg,
    output logic              trap_valid,
    output logic [2:0]        trap_cause,
    output logic [ADDR_W-1:0] trap_addr
);
    state_e             state_q, state_d;
    op_e                op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [TAG_W-1:0]   tag_q;
    logic [TAG_W-1:0]   ptag_q;

    cause_e             cause;
    logic [TAG_W-1:0]   wr_tag, ld_tag;
    logic [DATA_W-1:0]  wr_data;
    logic               flag_zero, flag_neg;
    logic               is_read_op, is_write_op, fault;

    tag_rule_eval u_rules (
        .op      (op_q),
        .mem_tag (mem_rtag),
        .reg_tag (tag_q),
        .ptr_tag (ptag_q),
        .cause   (cause)
    );

    tag_merge #(.DATA_W(DATA_W)) u_merge (
        .op        (op_q),
        .mem_tag   (mem_rtag),
        .mem_data  (mem_rdata),
        .reg_tag   (tag_q),
        .reg_data  (data_q),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data),
        .ld_tag    (ld_tag),
        .flag_zero (flag_zero),
        .flag_neg  (flag_neg)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_READ;
            ST_READ:  state_d = ST_CHECK;
            ST_CHECK: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            data_q  <= '0;
            tag_q   <= '0;
            ptag_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                op_q   <= op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
                tag_q  <= req_tag;
                ptag_q <= req_ptag;
            end
        end
    end

    assign is_read_op  = (op_q == OP_LOAD) || (op_q == OP_FETCH);
    assign is_write_op = (op_q == OP_STORE) || (op_q == OP_TAGMOD);
    assign fault       = (cause != CS_NONE);

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        mem_rd_en  = 1'b0;
        mem_wr_en  = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        mem_wtag   = '0;
        rsp_valid  = 1'b0;
        rsp_data   = '0;
        rsp_tag    = '0;
        cmp_zero   = 1'b0;
        cmp_neg    = 1'b0;
        trap_valid = 1'b0;
        trap_cause = CS_NONE;
        trap_addr  = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_READ: begin
                mem_rd_en = 1'b1;
                mem_addr  = addr_q;
            end
            ST_CHECK: begin
                mem_addr   = addr_q;
                rsp_valid  = 1'b1;
                trap_valid = fault;
                trap_cause = cause;
                if (fault) trap_addr = addr_q;
                if (is_read_op && !fault) begin
                    rsp_data = mem_rdata;
                    rsp_tag  = ld_tag;
                    cmp_zero = flag_zero;
                    cmp_neg  = flag_neg;
                end
                if (is_write_op && !fault) begin
                    mem_wr_en = 1'b1;
                    mem_wdata = wr_data;
                    mem_wtag  = wr_tag;
                end
            end
            default: req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/tagchk_props.sv
module tagchk_props (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] op_q,
    input logic       req_ready,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic [7:0] mem_rtag,
    input logic [7:0] mem_wtag,
    input logic       rsp_valid,
    input logic [7:0] rsp_tag,
    input logic       cmp_zero,
    input logic       cmp_neg,
    input logic       trap_valid,
    input logic [2:0] trap_cause
);
    // R2: a response always follows a memory read
    a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> rsp_valid);
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);
    // R3: uninitialized load traps with cause 1
    a_r3_uninit_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q == 2'd0 && !mem_rtag[7]) |-> (trap_valid && trap_cause == 3'd1));
    // R5: returned tag never carries place bits
    a_r5_place_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_tag[1:0] == 2'b00));
    // R6: store keeps the destination place bits
    a_r6_place_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && op_q == 2'd2) |-> (mem_wtag[1:0] == mem_rtag[1:0]));
    // R7: constant destination is never written by a store
    a_r7_const_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q == 2'd2 && mem_rtag[1]) |-> !mem_wr_en);
    // R11: pointer words give no compare flags
    a_r11_ptr_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && mem_rtag[5]) |-> (!cmp_zero && !cmp_neg));
    // R12: trap carries a cause and suppresses the write
    a_r12_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_cause != 3'd0 && !mem_wr_en));
endmodule

bind tagged_word_guard tagchk_props u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_q       (op_q),
    .req_ready  (req_ready),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_rtag   (mem_rtag),
    .mem_wtag   (mem_wtag),
    .rsp_valid  (rsp_valid),
    .rsp_tag    (rsp_tag),
    .cmp_zero   (cmp_zero),
    .cmp_neg    (cmp_neg),
    .trap_valid (trap_valid),
    .trap_cause (trap_cause)
);

// File: tb/test_tagged_word_guard.sv
`timescale 1ns/1ps
module test_tagged_word_guard;
    localparam int DW = 64;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [7:0]    req_tag = '0;
    logic [7:0]    req_ptag = '0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [7:0]    mem_wtag;
    logic [DW-1:0] mem_rdata = '0;
    logic [7:0]    mem_rtag = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [7:0]    rsp_tag;
    logic          cmp_zero, cmp_neg, trap_valid;
    logic [2:0]    trap_cause;
    logic [AW-1:0] trap_addr;

    logic [DW-1:0] mdat [0:15];
    logic [7:0]    mtag [0:15];

    int n_vec = 0;
    int n_bad = 0;

    // sampled results of the last request
    logic          s_rsp, s_trap, s_wr, s_cz, s_cn;
    logic [DW-1:0] s_data, s_wdata;
    logic [7:0]    s_tag, s_wtag;
    logic [2:0]    s_cause;
    logic [AW-1:0] s_taddr;

    always #2.5 clk = ~clk;

    tagged_word_guard #(.DATA_W(DW), .ADDR_W(AW)) i_tagged_word_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_tag(req_tag), .req_ptag(req_ptag), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wtag(mem_wtag), .mem_rdata(mem_rdata), .mem_rtag(mem_rtag),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
        .cmp_zero(cmp_zero), .cmp_neg(cmp_neg), .trap_valid(trap_valid),
        .trap_cause(trap_cause), .trap_addr(trap_addr)
    );

    // memory model: one-cycle read, write at the edge
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mdat[mem_addr[3:0]];
            mem_rtag  <= mtag[mem_addr[3:0]];
        end
        if (mem_wr_en) begin
            mdat[mem_addr[3:0]] <= mem_wdata;
            mtag[mem_addr[3:0]] <= mem_wtag;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] op, input int addr,
                          input logic [63:0] data, input logic [7:0] tag,
                          input logic [7:0] ptag);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = AW'(addr);
        req_data = data; req_tag = tag; req_ptag = ptag;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "read strobe", {63'd0, mem_rd_en}, 64'd1);
        chk("R2", "read addr", {48'd0, mem_addr}, 64'(addr));
        chk("R2", "ready while busy", {63'd0, req_ready}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        s_rsp = rsp_valid; s_data = rsp_data; s_tag = rsp_tag;
        s_cz = cmp_zero; s_cn = cmp_neg; s_trap = trap_valid;
        s_cause = trap_cause; s_taddr = trap_addr; s_wr = mem_wr_en;
        s_wdata = mem_wdata; s_wtag = mem_wtag;
        chk("R2", "response cycle", {63'd0, s_rsp}, 64'd1);
        @(posedge clk);
    endtask

    task automatic expect_trap(input string req, input int cause, input int addr);
        chk(req, "trap", {63'd0, s_trap}, 64'd1);
        chk(req, "cause", {61'd0, s_cause}, 64'(cause));
        chk("R12", "trap addr", {48'd0, s_taddr}, 64'(addr));
        chk(req, "write blocked", {63'd0, s_wr}, 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "ready", {63'd0, req_ready}, 64'd1);
        chk("R1", "rsp", {63'd0, rsp_valid}, 64'd0);
        chk("R1", "trap", {63'd0, trap_valid}, 64'd0);
        chk("R1", "rd", {63'd0, mem_rd_en}, 64'd0);
        chk("R1", "wr", {63'd0, mem_wr_en}, 64'd0);
    endtask

    task automatic t_load;
        do_req(2'd0, 1, 0, 0, 0);  // tag 93: init, zero flag, const, global
        chk("R3", "no trap", {63'd0, s_trap}, 64'd0);
        chk("R12", "cause none", {61'd0, s_cause}, 64'd0);
        chk("R3", "data", s_data, 64'h1234);
        chk("R5", "tag", {56'd0, s_tag}, 64'h90);
        chk("R11", "zero", {63'd0, s_cz}, 64'd1);
        chk("R11", "neg", {63'd0, s_cn}, 64'd0);
        do_req(2'd0, 2, 0, 0, 0);  // tag 40: uninitialized
        expect_trap("R3", 1, 2);
        chk("R11", "zero on trap", {63'd0, s_cz}, 64'd0);
    endtask

    task automatic t_fetch;
        do_req(2'd1, 3, 0, 0, 0);  // tag C1
        chk("R4", "no trap", {63'd0, s_trap}, 64'd0);
        chk("R5", "tag", {56'd0, s_tag}, 64'hC0);
        do_req(2'd1, 4, 0, 0, 0);  // tag 80: not executable
        expect_trap("R4", 2, 4);
        do_req(2'd1, 5, 0, 0, 0);  // tag 40: exec but uninitialized
        expect_trap("R4", 1, 5);
    endtask

    task automatic t_store_place;
        do_req(2'd2, 6, 64'hAA, 8'h8A, 8'h00);  // dest tag 81
        chk("R6", "no trap", {63'd0, s_trap}, 64'd0);
        chk("R6", "wr", {63'd0, s_wr}, 64'd1);
        chk("R6", "wtag", {56'd0, s_wtag}, 64'h89);
        chk("R6", "wdata", s_wdata, 64'hAA);
        chk("R12", "no store data", s_data, 64'd0);
        do_req(2'd0, 6, 0, 0, 0);
        chk("R6", "readback data", s_data, 64'hAA);
        chk("R5", "readback tag", {56'd0, s_tag}, 64'h88);
        chk("R11", "neg", {63'd0, s_cn}, 64'd1);
    endtask

    task automatic t_store_const;
        do_req(2'd2, 7, 64'hBEEF, 8'h80, 8'h00);  // dest tag 82
        expect_trap("R7", 3, 7);
        do_req(2'd0, 7, 0, 0, 0);
        chk("R7", "data unchanged", s_data, 64'h77);
    endtask

    task automatic t_store_ro;
        do_req(2'd2, 7, 64'h1, 8'h80, 8'h30);  // RO pointer onto const word
        expect_trap("R8", 4, 7);
        do_req(2'd2, 8, 64'h55, 8'h80, 8'h20);  // pointer, writable
        chk("R8", "rw ptr wr", {63'd0, s_wr}, 64'd1);
        do_req(2'd2, 8, 64'h66, 8'h80, 8'h10);  // not a pointer: bit4 ignored
        chk("R8", "non-ptr wr", {63'd0, s_wr}, 64'd1);
        do_req(2'd0, 8, 0, 0, 0);
        chk("R8", "readback", s_data, 64'h66);
    endtask

    task automatic t_store_type;
        do_req(2'd2, 9, 64'h9, 8'h80, 8'h00);  // dest A0: initialized pointer
        expect_trap("R9", 5, 9);
        do_req(2'd2, 10, 64'hA, 8'hA0, 8'h00);  // dest 00: uninitialized
        chk("R9", "wr uninit", {63'd0, s_wr}, 64'd1);
        chk("R9", "wtag", {56'd0, s_wtag}, 64'hA0);
    endtask

    task automatic t_tagmod;
        do_req(2'd3, 9, 64'hFFFF, 8'h82, 8'h00);
        chk("R10", "no trap", {63'd0, s_trap}, 64'd0);
        chk("R10", "wtag", {56'd0, s_wtag}, 64'h82);
        chk("R10", "data kept", s_wdata, 64'h99);
        do_req(2'd3, 7, 0, 8'h80, 8'h00);  // constant word
        chk("R10", "const no trap", {63'd0, s_trap}, 64'd0);
        chk("R10", "const wr", {63'd0, s_wr}, 64'd1);
        do_req(2'd2, 7, 64'h42, 8'h80, 8'h00);  // now writable
        chk("R10", "store after clear", {63'd0, s_wr}, 64'd1);
    endtask

    task automatic t_compare;
        do_req(2'd0, 11, 0, 0, 0);  // tag B4: pointer, RO, carry
        chk("R11", "ptr zero", {63'd0, s_cz}, 64'd0);
        chk("R11", "ptr neg", {63'd0, s_cn}, 64'd0);
        chk("R5", "ptr tag", {56'd0, s_tag}, 64'hB4);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mdat[i] = '0; mtag[i] = '0; end
        mdat[1] = 64'h1234; mtag[1] = 8'h93;
        mtag[2] = 8'h40;
        mtag[3] = 8'hC1;
        mtag[4] = 8'h80;
        mtag[5] = 8'h40;
        mtag[6] = 8'h81;
        mdat[7] = 64'h77;   mtag[7] = 8'h82;
        mtag[8] = 8'h80;
        mdat[9] = 64'h99;   mtag[9] = 8'hA0;
        mtag[10] = 8'h00;
        mtag[11] = 8'hB4;
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_fetch();
        t_store_place();
        t_store_const();
        t_store_ro();
        t_store_type();
        t_tagmod();
        t_compare();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule